// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two binary floating-point operands in the common 32-bit interchange format (1 sign bit, 8-bit biased exponent, 23-bit fraction) and returns their rounded product. The rounding rule is chosen per operation. It accepts one operation per clock and returns each result exactly two clocks later. The exponent and fraction widths are parameters, so the same code also builds narrower formats.

The magnitude path adds the two biased exponents and takes away one bias. It forms the full double-width product of the two significands, each of which carries its hidden one. Because each significand lies in [1,2), the raw product lies in [1,4), so normalisation is a single optional right shift. The bits below the kept significand reduce to a round bit and a sticky bit, and these drive the rounding. The sign is the XOR of the operand signs and does not depend on the magnitude path. Zero, infinity and NaN operands take a separate special path. Subnormal operands are read as zero, and a result too small for the normal range is flushed to zero.

Each of the two pipeline stages has its own occupancy state, `STG_EMPTY` or `STG_FULL`. Stage one loads (EMPTY→FULL, or FULL→FULL) on a cycle with `in_valid` high and drains (FULL→EMPTY) on a cycle without it. Stage two follows stage one's state one cycle later, and `out_valid` is high exactly when stage two is `STG_FULL`.

Top module: `fp_mul_unit`

## Requirements
- R1: For every result that is not NaN, the sign bit equals the XOR of the two operand sign bits.
- R2: For normal operands, the result's biased exponent is the sum of the operand biased exponents minus 127. It is one higher when the significand product is 2 or more, in which case the product is shifted right by one place.
- R3: With `rnd_mode` = 0 (nearest, ties to even), the kept significand is incremented when the round bit is 1 and either the sticky bit or the kept least significant bit is 1.
- R4: With `rnd_mode` = 1 (toward zero), the result is truncated. With 2 (toward +infinity), an inexact positive result is incremented. With 3 (toward −infinity), an inexact negative result is incremented.
- R5: When rounding carries out of the significand, the result fraction is zero and the exponent rises by one.
- R6: A rounded biased exponent of 255 or more gives an infinity of the product's sign (exponent all ones, fraction zero) with `ovf_flag` = 1, in every rounding mode.
- R7: A rounded biased exponent of 0 or less gives a zero of the product's sign with `unf_flag` = 1. An operand with exponent field 0 (zero or subnormal) is treated as zero, and a product involving it raises no flag.
- R8: A NaN operand, or zero times infinity, gives the NaN pattern 0x7FC00000 with both flags 0.
- R9: Infinity times any nonzero non-NaN value gives an infinity of the XOR sign. Zero times any finite value gives a zero of the XOR sign. Both flags are 0 in both cases.
- R10: `out_valid` is high exactly two cycles after each cycle with `in_valid` high, back-to-back operations are accepted every cycle, and `out_valid` is low otherwise. After reset, `out_valid`, `result` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operands and rounding mode are valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| rnd_mode | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward −inf |
| out_valid | output | 1 | `result` and flags belong to an operation issued two cycles earlier |
| result | output | 32 | Rounded product |
| ovf_flag | output | 1 | Result overflowed to infinity |
| unf_flag | output | 1 | Result underflowed to zero |

## Verification
Assertions check the following on every cycle:
- The two-cycle valid latency, with no result appearing without an issued operation.
- The sign relation for non-NaN results.
- The infinity pattern whenever `ovf_flag` is set, and the zero pattern whenever `unf_flag` is set.
- That the two flags are never set together.
- That a NaN on the first operand always yields the NaN pattern.

The exact rounding decisions in each mode, the carry-out renormalisation, the exponent arithmetic and the special-operand table can only be shown by the bench's scenarios. These are an exhaustive sweep of a narrow 8-bit format (4 exponent bits, 3 fraction bits) across the rounding modes, and directed single-precision cases at the overflow, underflow and special boundaries.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    // Rounding selector; the encoding is part of the port contract.
    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'd0,
        RND_TO_ZERO   = 2'd1,
        RND_UP        = 2'd2,
        RND_DOWN      = 2'd3
    } rnd_mode_e;

    // Operand classification after unpacking.
    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } opnd_class_e;

    // Which path produces the packed result.
    typedef enum logic [1:0] {
        OUT_NUM,
        OUT_ZERO,
        OUT_INF,
        OUT_NAN
    } out_kind_e;

    // Occupancy of one pipeline stage.
    typedef enum logic {
        STG_EMPTY,
        STG_FULL
    } stage_state_e;

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0]      op,
    output logic              sgn,
    output logic [EXP_W-1:0]  bexp,
    output logic [FRAC_W:0]   sig,
    output opnd_class_e       cls
);

    logic exp_ones;
    logic exp_clear;
    logic frac_clear;

    always_comb begin
        sgn        = op[W-1];
        bexp       = op[W-2 -: EXP_W];
        exp_ones   = &bexp;
        exp_clear  = ~|bexp;
        frac_clear = ~|op[FRAC_W-1:0];
        // Hidden one only for normal encodings; subnormals are read as zero.
        sig        = {~exp_clear, op[FRAC_W-1:0]};
        if (exp_ones) begin
            cls = frac_clear ? CLS_INF : CLS_NAN;
        end else if (exp_clear) begin
            cls = CLS_ZERO;
        end else begin
            cls = CLS_NORM;
        end
    end

endmodule

// File: rtl/fpm_round.sv
module fpm_round
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int SW    = FRAC_W + 1,
    localparam int PW    = 2 * SW,
    localparam int XW    = EXP_W + 3
) (
    input  logic                 sign,
    input  out_kind_e            kind,
    input  logic signed [XW-1:0] exp_sum,
    input  logic [PW-1:0]        prod,
    input  rnd_mode_e            mode,
    output logic [W-1:0]         res,
    output logic                 ovf,
    output logic                 unf
);

    localparam logic signed [XW-1:0] EXP_TOP = XW'((1 << EXP_W) - 1);
    localparam logic signed [XW-1:0] EXP_ONE = XW'(1);
    localparam logic [FRAC_W-1:0]    QNAN_FR = FRAC_W'(1) << (FRAC_W - 1);

    logic                 top_bit;
    logic [SW-1:0]        mant;
    logic                 rnd_bit;
    logic                 stk_bit;
    logic                 bump;
    logic [SW:0]          mant_inc;
    logic signed [XW-1:0] exp_f;
    logic                 unused_hidden;

    // Normalise: the product is in [1,4), so at most one right shift.
    always_comb begin
        top_bit = prod[PW-1];
        if (top_bit) begin
            mant    = prod[PW-1 -: SW];
            rnd_bit = prod[PW-1-SW];
            stk_bit = |prod[PW-2-SW:0];
        end else begin
            mant    = prod[PW-2 -: SW];
            rnd_bit = prod[PW-2-SW];
            stk_bit = |prod[PW-3-SW:0];
        end
    end

    // Round-increment decision per mode.
    always_comb begin
        unique case (mode)
            RND_NEAR_EVEN: bump = rnd_bit & (stk_bit | mant[0]);
            RND_TO_ZERO:   bump = 1'b0;
            RND_UP:        bump = ~sign & (rnd_bit | stk_bit);
            RND_DOWN:      bump = sign & (rnd_bit | stk_bit);
        endcase
        mant_inc      = {1'b0, mant} + {{SW{1'b0}}, bump};
        unused_hidden = mant_inc[SW-1];
        exp_f         = exp_sum
                      + $signed({{(XW-1){1'b0}}, top_bit})
                      + $signed({{(XW-1){1'b0}}, mant_inc[SW]});
    end

    // Pack: special paths first, then range check of the rounded exponent.
    always_comb begin
        ovf = 1'b0;
        unf = 1'b0;
        unique case (kind)
            OUT_NAN:  res = {1'b0, {EXP_W{1'b1}}, QNAN_FR};
            OUT_INF:  res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            OUT_ZERO: res = {sign, {(W-1){1'b0}}};
            OUT_NUM: begin
                if (exp_f >= EXP_TOP) begin
                    ovf = 1'b1;
                    res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                end else if (exp_f < EXP_ONE) begin
                    unf = 1'b1;
                    res = {sign, {(W-1){1'b0}}};
                end else begin
                    res = {sign, exp_f[EXP_W-1:0], mant_inc[FRAC_W-1:0]};
                end
            end
        endcase
    end

endmodule

// File: rtl/fp_mul_unit.sv
module fp_mul_unit
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int SW    = FRAC_W + 1,
    localparam int PW    = 2 * SW,
    localparam int XW    = EXP_W + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [1:0]    rnd_mode,
    output logic          out_valid,
    output logic [W-1:0]  result,
    output logic          ovf_flag,
    output logic          unf_flag
);

    localparam logic signed [XW-1:0] BIAS_X = XW'((1 << (EXP_W - 1)) - 1);
    localparam logic [W-1:0] NAN_WORD =
        {1'b0, {EXP_W{1'b1}}, FRAC_W'(1) << (FRAC_W - 1)};

    // ---------------- operand unpack (one per operand) ----------------
    logic [W-1:0]      opnd  [2];
    logic              sgn   [2];
    logic [EXP_W-1:0]  bexp  [2];
    logic [FRAC_W:0]   sig   [2];
    opnd_class_e       cls   [2];

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    for (genvar g = 0; g < 2; g++) begin : g_unpack
        fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
            .op   (opnd[g]),
            .sgn  (sgn[g]),
            .bexp (bexp[g]),
            .sig  (sig[g]),
            .cls  (cls[g])
        );
    end

    // ---------------- stage 1 combinational ----------------
    logic                 sign_c;
    out_kind_e            kind_c;
    logic signed [XW-1:0] exp_sum_c;
    logic [PW-1:0]        prod_c;

    always_comb begin
        sign_c    = sgn[0] ^ sgn[1];
        exp_sum_c = $signed({3'b000, bexp[0]}) + $signed({3'b000, bexp[1]}) - BIAS_X;
        prod_c    = {{SW{1'b0}}, sig[0]} * {{SW{1'b0}}, sig[1]};
        if (cls[0] == CLS_NAN || cls[1] == CLS_NAN
            || (cls[0] == CLS_ZERO && cls[1] == CLS_INF)
            || (cls[0] == CLS_INF && cls[1] == CLS_ZERO)) begin
            kind_c = OUT_NAN;
        end else if (cls[0] == CLS_INF || cls[1] == CLS_INF) begin
            kind_c = OUT_INF;
        end else if (cls[0] == CLS_ZERO || cls[1] == CLS_ZERO) begin
            kind_c = OUT_ZERO;
        end else begin
            kind_c = OUT_NUM;
        end
    end

    // ---------------- stage occupancy state machines ----------------
    stage_state_e s1_state, s1_next;
    stage_state_e s2_state, s2_next;

    always_comb begin
        unique case (s1_state)
            STG_EMPTY: s1_next = in_valid ? STG_FULL : STG_EMPTY;
            STG_FULL:  s1_next = in_valid ? STG_FULL : STG_EMPTY;
        endcase
        unique case (s2_state)
            STG_EMPTY: s2_next = (s1_state == STG_FULL) ? STG_FULL : STG_EMPTY;
            STG_FULL:  s2_next = (s1_state == STG_FULL) ? STG_FULL : STG_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_state <= STG_EMPTY;
            s2_state <= STG_EMPTY;
        end else begin
            s1_state <= s1_next;
            s2_state <= s2_next;
        end
    end

    // ---------------- stage 1 registers ----------------
    logic                 s1_sign;
    out_kind_e            s1_kind;
    logic signed [XW-1:0] s1_exp;
    logic [PW-1:0]        s1_prod;
    rnd_mode_e            s1_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_sign <= 1'b0;
            s1_kind <= OUT_ZERO;
            s1_exp  <= '0;
            s1_prod <= '0;
            s1_mode <= RND_NEAR_EVEN;
        end else if (in_valid) begin
            s1_sign <= sign_c;
            s1_kind <= kind_c;
            s1_exp  <= exp_sum_c;
            s1_prod <= prod_c;
            s1_mode <= rnd_mode_e'(rnd_mode);
        end
    end

    // ---------------- stage 2: round, pack, register ----------------
    logic [W-1:0] res_c;
    logic         ovf_c;
    logic         unf_c;

    fpm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .sign    (s1_sign),
        .kind    (s1_kind),
        .exp_sum (s1_exp),
        .prod    (s1_prod),
        .mode    (s1_mode),
        .res     (res_c),
        .ovf     (ovf_c),
        .unf     (unf_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else if (s1_state == STG_FULL) begin
            result   <= res_c;
            ovf_flag <= ovf_c;
            unf_flag <= unf_c;
        end
    end

    always_comb out_valid = (s2_state == STG_FULL);

    // ---------------- assertions ----------------
    logic out_is_nan;
    logic a_in_nan;
    always_comb begin
        out_is_nan = (&result[W-2 -: EXP_W]) && (|result[FRAC_W-1:0]);
        a_in_nan   = (&op_a[W-2 -: EXP_W]) && (|op_a[FRAC_W-1:0]);
    end

    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    a_r1_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_nan) |-> result[W-1] == ($past(op_a[W-1], 2) ^ $past(op_b[W-1], 2)));

    a_r6_ovf_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> (result[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

    a_r7_unf_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |-> (result[W-2:0] == '0));

    a_r6_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_flag && unf_flag));

    a_r8_nan_prop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_in_nan) |=> ##1 (result == NAN_WORD && !ovf_flag && !unf_flag));

endmodule

// File: tb/fp_mul_unit_tb.sv
`timescale 1ns/1ps
module fp_mul_unit_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int cycle = 0;
    always @(posedge clk) cycle <= cycle + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // ---------- single-precision instance ----------
    logic        v32;
    logic [31:0] a32, b32;
    logic [1:0]  m32;
    logic        ov32, ovf32, unf32;
    logic [31:0] r32;

    fp_mul_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(v32), .op_a(a32), .op_b(b32),
        .rnd_mode(m32), .out_valid(ov32), .result(r32), .ovf_flag(ovf32), .unf_flag(unf32)
    );

    // ---------- narrow 8-bit instance for the exhaustive sweep ----------
    logic       v8;
    logic [7:0] a8, b8;
    logic [1:0] m8;
    logic       ov8, ovf8, unf8;
    logic [7:0] r8;

    fp_mul_unit #(.EXP_W(4), .FRAC_W(3)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .in_valid(v8), .op_a(a8), .op_b(b8),
        .rnd_mode(m8), .out_valid(ov8), .result(r8), .ovf_flag(ovf8), .unf_flag(unf8)
    );

    // ---------- arithmetic reference: exact product, remainder compare ----------
    function automatic logic [33:0] ref_mul(input int ew, input int fw,
                                            input logic [31:0] a, input logic [31:0] b,
                                            input logic [1:0] m);
        longint emax, bias, fmask, ea, eb, fa, fb, p, q, rem, half, e, word;
        int s, msb, n;
        bit an, ai, az, bn, bi, bz, inc, ov, un;
        emax  = (longint'(1) << ew) - 1;
        bias  = (longint'(1) << (ew - 1)) - 1;
        fmask = (longint'(1) << fw) - 1;
        ea = (longint'(a) >> fw) & emax;  fa = longint'(a) & fmask;
        eb = (longint'(b) >> fw) & emax;  fb = longint'(b) & fmask;
        s  = int'(a[ew+fw] ^ b[ew+fw]);
        an = (ea == emax) && (fa != 0);  ai = (ea == emax) && (fa == 0);  az = (ea == 0);
        bn = (eb == emax) && (fb != 0);  bi = (eb == emax) && (fb == 0);  bz = (eb == 0);
        ov = 1'b0; un = 1'b0;
        if (an || bn || (ai && bz) || (az && bi)) begin
            word = (emax << fw) | (longint'(1) << (fw - 1));
        end else if (ai || bi) begin
            word = (longint'(s) << (ew + fw)) | (emax << fw);
        end else if (az || bz) begin
            word = longint'(s) << (ew + fw);
        end else begin
            p = (fa | (longint'(1) << fw)) * (fb | (longint'(1) << fw));
            msb = 0;
            for (int k = 0; k < 63; k++) if (p[k]) msb = k;
            n    = msb - fw;
            q    = p >> n;
            rem  = p & ((longint'(1) << n) - 1);
            half = longint'(1) << (n - 1);
            e    = ea + eb - bias + longint'(n - fw);
            case (m)
                2'd0:    inc = (rem > half) || (rem == half && q[0]);
                2'd1:    inc = 1'b0;
                2'd2:    inc = (s == 0) && (rem != 0);
                default: inc = (s == 1) && (rem != 0);
            endcase
            q = q + longint'(inc);
            if (q == (longint'(1) << (fw + 1))) begin
                q = q >> 1;
                e = e + 1;
            end
            if (e >= emax) begin
                ov = 1'b1;
                word = (longint'(s) << (ew + fw)) | (emax << fw);
            end else if (e <= 0) begin
                un = 1'b1;
                word = longint'(s) << (ew + fw);
            end else begin
                word = (longint'(s) << (ew + fw)) | (e << fw) | (q & fmask);
            end
        end
        return {ov, un, 32'(word)};
    endfunction

    // ---------- expectation queues and monitors ----------
    logic [33:0] q32_e[$];  int q32_c[$];  string q32_t[$];
    logic [33:0] q8_e[$];   int q8_c[$];   string q8_t[$];

    always @(negedge clk) if (rst_n && !done) begin
        if (q32_c.size() != 0 && q32_c[0] + 2 == cycle) begin
            logic [33:0] e; string t;
            e = q32_e.pop_front(); void'(q32_c.pop_front()); t = q32_t.pop_front();
            n_chk++;
            if (!ov32 || {ovf32, unf32, r32} != e) begin
                n_bad++;
                $display("FAIL %s: got v=%0b ovf=%0b unf=%0b res=%08h, expected v=1 ovf=%0b unf=%0b res=%08h",
                         t, ov32, ovf32, unf32, r32, e[33], e[32], e[31:0]);
            end
        end else if (ov32) begin
            n_chk++; n_bad++;
            $display("FAIL R10: out_valid=1 with nothing issued two cycles earlier, expected 0");
        end
    end

    always @(negedge clk) if (rst_n && !done) begin
        if (q8_c.size() != 0 && q8_c[0] + 2 == cycle) begin
            logic [33:0] e; string t;
            e = q8_e.pop_front(); void'(q8_c.pop_front()); t = q8_t.pop_front();
            n_chk++;
            if (!ov8 || {ovf8, unf8, r8} != {e[33:32], e[7:0]}) begin
                n_bad++;
                $display("FAIL %s: got v=%0b ovf=%0b unf=%0b res=%02h, expected v=1 ovf=%0b unf=%0b res=%02h",
                         t, ov8, ovf8, unf8, r8, e[33], e[32], e[7:0]);
            end
        end else if (ov8) begin
            n_chk++; n_bad++;
            $display("FAIL R10 small: out_valid=1 with nothing issued, expected 0");
        end
    end

    // ---------- drivers (called at a falling edge) ----------
    task automatic go32(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                        input logic [33:0] e, input string t);
        v32 = 1'b1; a32 = a; b32 = b; m32 = m;
        q32_e.push_back(e); q32_c.push_back(cycle); q32_t.push_back(t);
        @(negedge clk);
        v32 = 1'b0;
    endtask

    task automatic go8(input logic [7:0] a, input logic [7:0] b, input logic [1:0] m,
                       input logic [33:0] e, input string t);
        v8 = 1'b1; a8 = a; b8 = b; m8 = m;
        q8_e.push_back(e); q8_c.push_back(cycle); q8_t.push_back(t);
        @(negedge clk);
        v8 = 1'b0;
    endtask

    task automatic chk_reset(input logic v, input logic [31:0] r, input logic o, input logic u,
                             input string t);
        n_chk++;
        if (v !== 1'b0 || r !== 32'h0 || o !== 1'b0 || u !== 1'b0) begin
            n_bad++;
            $display("FAIL %s: got v=%0b res=%08h ovf=%0b unf=%0b, expected all 0", t, v, r, o, u);
        end
    endtask

    function automatic logic [33:0] x(input logic o, input logic u, input logic [31:0] r);
        return {o, u, r};
    endfunction

    // ---------- main sequence ----------
    initial begin
        v32 = 0; a32 = 0; b32 = 0; m32 = 0;
        v8 = 0; a8 = 0; b8 = 0; m8 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset(ov32, r32, ovf32, unf32, "R10 reset");
        chk_reset(ov8, {24'h0, r8}, ovf8, unf8, "R10 reset small");

        // R2: exponent sum and one-place normalisation
        go32(32'h3FC00000, 32'h40000000, 2'd0, x(0,0,32'h40400000), "R2 1.5*2");
        go32(32'h40400000, 32'h40A00000, 2'd0, x(0,0,32'h41700000), "R2 3*5");
        go32(32'h40400000, 32'h40400000, 2'd0, x(0,0,32'h41100000), "R2 3*3 shift");
        @(negedge clk);   // idle gap: R10 no result expected
        // R1: sign
        go32(32'hBE200000, 32'h40000000, 2'd0, x(0,0,32'hBEA00000), "R1 neg*pos");
        go32(32'hC0400000, 32'hC0400000, 2'd0, x(0,0,32'h41100000), "R1 neg*neg");
        // R3 / R4: rounding modes, inexact below half
        go32(32'h3F800001, 32'h3F800001, 2'd0, x(0,0,32'h3F800002), "R3 nearest");
        go32(32'h3F800001, 32'h3F800001, 2'd1, x(0,0,32'h3F800002), "R4 to zero");
        go32(32'h3F800001, 32'h3F800001, 2'd2, x(0,0,32'h3F800003), "R4 up pos");
        go32(32'hBF800001, 32'h3F800001, 2'd3, x(0,0,32'hBF800003), "R4 down neg");
        go32(32'hBF800001, 32'h3F800001, 2'd2, x(0,0,32'hBF800002), "R4 up neg");
        // R3: exact tie, odd lsb rounds up
        go32(32'h3FC00000, 32'h3F800001, 2'd0, x(0,0,32'h3FC00002), "R3 tie odd");
        go32(32'h3FC00000, 32'h3F800001, 2'd1, x(0,0,32'h3FC00001), "R4 tie trunc");
        for (int k = 0; k < 4; k++)
            go32(32'h3FB504F3, 32'h3FB504F3, 2'(k), ref_mul(8, 23, 32'h3FB504F3, 32'h3FB504F3, 2'(k)),
                 "R3 R4 near two");
        // R6: overflow
        go32(32'h7F7FFFFF, 32'h40000000, 2'd1, x(1,0,32'h7F800000), "R6 overflow pos");
        go32(32'hFF7FFFFF, 32'h40000000, 2'd0, x(1,0,32'hFF800000), "R6 overflow neg");
        // R7: underflow and subnormal input
        go32(32'h00800000, 32'h3F000000, 2'd0, x(0,1,32'h00000000), "R7 underflow");
        go32(32'h80800000, 32'h3F000000, 2'd2, x(0,1,32'h80000000), "R7 underflow neg");
        go32(32'h00000001, 32'h3F800000, 2'd0, x(0,0,32'h00000000), "R7 subnormal in");
        // R8: NaN cases
        go32(32'h7FC00001, 32'h3F800000, 2'd0, x(0,0,32'h7FC00000), "R8 nan a");
        go32(32'h3F800000, 32'hFF800001, 2'd0, x(0,0,32'h7FC00000), "R8 nan b");
        go32(32'h00000000, 32'h7F800000, 2'd0, x(0,0,32'h7FC00000), "R8 zero*inf");
        go32(32'hFF800000, 32'h80000000, 2'd0, x(0,0,32'h7FC00000), "R8 inf*zero");
        // R9: infinity and zero
        go32(32'hFF800000, 32'h40000000, 2'd0, x(0,0,32'hFF800000), "R9 inf*finite");
        go32(32'h7F800000, 32'hFF800000, 2'd0, x(0,0,32'hFF800000), "R9 inf*inf");
        go32(32'h80000000, 32'h40400000, 2'd0, x(0,0,32'h80000000), "R9 zero*finite");

        // R5: carry-out renormalisation in the narrow format (1.011^2 = 1.111001)
        go8(8'h3B, 8'h3B, 2'd2, x(0,0,32'h40), "R5 carry up");
        go8(8'h3B, 8'h3B, 2'd0, x(0,0,32'h3F), "R5 no carry nearest");

        // Exhaustive narrow sweep, back to back (R1 R2 R3 R4 R5 R6 R7 R8 R9)
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                go8(8'(i), 8'(j), 2'((i + j) % 4),
                    ref_mul(4, 3, 32'(i), 32'(j), 2'((i + j) % 4)), "sweep R2 R3 R4 R5 R6 R7");
            end
        end
        repeat (5) @(negedge clk);
        if (q32_c.size() != 0 || q8_c.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R10: %0d results missing, expected 0", q32_c.size() + q8_c.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL R10 watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule